// File: doc/BRIEF.md
# Memory-Mapped Bus Width Downsizer

This block connects a 32-bit memory-mapped master to a 16-bit on-chip RAM port. Every master access is turned into one or two 16-bit slave accesses. Reads always fetch both halves of the addressed word and merge them into a single 32-bit result. Writes issue only the halves whose byte enables are set. The slave has a fixed read latency of `RD_LAT` cycles and gives no flow control back. The adapter therefore keeps the master's wait request high until the access is finished.

With `POST_WR` set, a write that reaches an idle adapter is taken into a holding register. The master is released in that same cycle, and the halves are issued to the RAM afterwards. Any master access that arrives while such a write is still being issued is stalled until the holding register is empty. Master addresses are byte addresses, so bits [1:0] are ignored. Slave addresses count 16-bit words, and bit 0 selects the half.

Top module: `bus_width_downsizer`

## Requirements
- R1: A master read issues exactly two slave reads in consecutive cycles. The first goes to slave address {m_addr[ADDR_W-1:2],0}, the second to {m_addr[ADDR_W-1:2],1}, and both carry s_be = 2'b11.
- R2: The read result m_rdata is {second slave word, first slave word} with no zero padding. m_rvalid is high for exactly one cycle per master read.
- R3: Each slave read word is taken exactly RD_LAT cycles (1 or 2) after the cycle in which its s_read was high. A read presented to an idle adapter sees m_waitreq high for exactly 3+RD_LAT cycles.
- R4: For a write, the lower half is issued only if m_be[1:0] is nonzero and the upper half only if m_be[3:2] is nonzero. A write with all byte enables zero makes no slave access.
- R5: The lower write half carries m_wdata[15:0] with s_be = m_be[1:0]. The upper half carries m_wdata[31:16] with s_be = m_be[3:2]. Bytes whose enable is low keep their old contents, and s_read and s_write are never high together.
- R6: When both halves of a write are needed, the lower half is issued first and the upper half in the very next cycle.
- R7: With POST_WR = 0, a write holds m_waitreq high for 1 + (number of halves issued) cycles. It is released in the cycle after the last half, and no slave strobe is active in that cycle.
- R8: With POST_WR = 1, a write reaching an idle adapter is accepted with m_waitreq low in the same cycle, and its halves are issued in the following cycles.
- R9: An access that arrives while a posted write is still being issued is held for as long as that drain lasts. It then runs normally, so a read right after a posted write to the same word returns the written data.
- R10: Synchronous active-high reset returns the adapter to idle. It drops any posted half not yet issued, keeps s_read, s_write and m_rvalid low, and leaves m_waitreq low while no master command is present.
- R11: m_rvalid is asserted only in the cycle in which a master read completes with m_waitreq low, and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | ADDR_W | Master byte address |
| m_read | input | 1 | Master read command, held while m_waitreq is high |
| m_write | input | 1 | Master write command, held while m_waitreq is high |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables (reads use all four) |
| m_waitreq | output | 1 | Stall to the master; the command completes in a cycle where it is low |
| m_rdata | output | 32 | Assembled read word |
| m_rvalid | output | 1 | One-cycle read completion marker |
| s_addr | output | ADDR_W-1 | Slave 16-bit word address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_wdata | output | 16 | Slave write data |
| s_be | output | 2 | Slave byte enables |
| s_rdata | input | 16 | Slave read data, valid RD_LAT cycles after s_read |

## Verification
The bench's RAM model drives a poison value on its read data in every cycle except the exact latency slot. A design that samples one cycle early or late, or pads the upper half, returns that poison or zeros in place of the stored words. Odd byte-enable patterns (single upper byte, single lower byte, one byte in each half, none at all) expose designs that issue empty halves, route the wrong lane or overwrite unenabled bytes. A read placed directly behind a posted write checks that the read is stalled for the drain and returns the new data rather than the old. Reset asserted while the second half of a posted write is still pending checks that the half is dropped.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    // Bus geometry shared by every part of the adapter
    localparam int unsigned MST_W  = 32;
    localparam int unsigned SLV_W  = 16;
    localparam int unsigned MST_BE = MST_W / 8;
    localparam int unsigned SLV_BE = SLV_W / 8;
    localparam int unsigned N_HALF = MST_W / SLV_W;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LO    = 3'd1,
        ST_HI    = 3'd2,
        ST_RWAIT = 3'd3,
        ST_DONE  = 3'd4
    } bwd_state_e;

    // Assembled read word: upper slave word above lower slave word
    typedef struct packed {
        logic [SLV_W-1:0] hi;
        logic [SLV_W-1:0] lo;
    } bwd_word_t;

    // One accepted master access
    typedef struct packed {
        logic              rd;
        logic              posted;
        logic              need_lo;
        logic              need_hi;
        logic [MST_W-1:0]  wdata;
        logic [MST_BE-1:0] be;
    } bwd_job_t;

    // Build a job from the master command; reads always use every lane
    function automatic bwd_job_t make_job(input logic              is_rd,
                                          input logic              post_en,
                                          input logic [MST_W-1:0]  wdata,
                                          input logic [MST_BE-1:0] be);
        bwd_job_t j;
        j.rd      = is_rd;
        j.posted  = post_en && !is_rd;
        j.be      = is_rd ? {MST_BE{1'b1}} : be;
        j.need_lo = |j.be[SLV_BE-1:0];
        j.need_hi = |j.be[MST_BE-1:SLV_BE];
        j.wdata   = wdata;
        return j;
    endfunction

    // State after the last slave half has been issued
    function automatic bwd_state_e tail_step(input bwd_job_t j);
        if (j.rd)     return ST_RWAIT;
        if (j.posted) return ST_IDLE;
        return ST_DONE;
    endfunction

    // State after the lower half
    function automatic bwd_state_e after_lo(input bwd_job_t j);
        if (j.need_hi) return ST_HI;
        return tail_step(j);
    endfunction

    // First state for a freshly accepted job
    function automatic bwd_state_e first_step(input bwd_job_t j);
        if (j.need_lo) return ST_LO;
        return after_lo(j);
    endfunction

endpackage

// File: rtl/bwd_ctrl.sv
// Command sequencer: accepts master commands, holds the job and walks the
// halves. Also produces the stall towards the master.
module bwd_ctrl
    import bwd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter bit POST_WR = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   m_addr,
    input  logic                m_read,
    input  logic                m_write,
    input  logic [MST_W-1:0]    m_wdata,
    input  logic [MST_BE-1:0]   m_be,
    input  logic                hi_arrive,
    output logic                m_waitreq,
    output bwd_state_e          state,
    output logic                job_rd,
    output logic [MST_W-1:0]    job_wdata,
    output logic [MST_BE-1:0]   job_be,
    output logic [ADDR_W-3:0]   job_waddr
);

    bwd_job_t   job_q;
    bwd_job_t   new_job;
    bwd_state_e nxt;
    logic       cmd;
    logic       take;
    logic       accept;
    logic       unused_lsb;

    // Byte offset inside the 32-bit word plays no part in the split
    assign unused_lsb = ^m_addr[1:0];

    assign cmd     = m_read || m_write;
    assign new_job = make_job(m_read, POST_WR, m_wdata, m_be);
    assign take    = (state == ST_IDLE) && cmd;

    // Completion: a finished job, or a posted write taken on entry
    assign accept    = (state == ST_DONE) || (take && new_job.posted);
    assign m_waitreq = cmd && !accept;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cmd) nxt = first_step(new_job);
            ST_LO:    nxt = after_lo(job_q);
            ST_HI:    nxt = tail_step(job_q);
            ST_RWAIT: if (hi_arrive) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            job_q     <= '0;
            job_waddr <= '0;
        end else begin
            state <= nxt;
            if (take) begin
                job_q     <= new_job;
                job_waddr <= m_addr[ADDR_W-1:2];
            end
        end
    end

    assign job_rd    = job_q.rd;
    assign job_wdata = job_q.wdata;
    assign job_be    = job_q.be;

endmodule

// File: rtl/bwd_slv_mux.sv
// Slave side drive: decodes the strobes from the sequencer state and steers
// the selected 16-bit lane of the held job onto the slave port.
module bwd_slv_mux
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  bwd_state_e          state,
    input  logic                job_rd,
    input  logic [MST_W-1:0]    job_wdata,
    input  logic [MST_BE-1:0]   job_be,
    input  logic [ADDR_W-3:0]   job_waddr,
    output logic [ADDR_W-2:0]   s_addr,
    output logic                s_read,
    output logic                s_write,
    output logic [SLV_W-1:0]    s_wdata,
    output logic [SLV_BE-1:0]   s_be
);

    logic [SLV_W-1:0]  lane_d [N_HALF];
    logic [SLV_BE-1:0] lane_b [N_HALF];
    logic              active;
    logic              upper;

    // Split the held word into slave-width lanes
    for (genvar h = 0; h < N_HALF; h++) begin : g_lane
        assign lane_d[h] = job_wdata[h*SLV_W +: SLV_W];
        assign lane_b[h] = job_be[h*SLV_BE +: SLV_BE];
    end

    assign active  = (state == ST_LO) || (state == ST_HI);
    assign upper   = (state == ST_HI);

    assign s_read  = active && job_rd;
    assign s_write = active && !job_rd;
    assign s_addr  = {job_waddr, upper};
    assign s_wdata = lane_d[upper];
    assign s_be    = lane_b[upper];

endmodule

// File: rtl/bwd_rd_gather.sv
// Read return path: a tag pipeline RD_LAT deep marks the cycle in which each
// issued read's data sits on the slave bus and which half it is.
module bwd_rd_gather
    import bwd_pkg::*;
#(
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_read,
    input  logic              s_upper,
    input  logic [SLV_W-1:0]  s_rdata,
    output logic              hi_arrive,
    output logic [MST_W-1:0]  m_rdata,
    output logic              m_rvalid
);

    logic             arr_v;
    logic             arr_hi;
    logic [SLV_W-1:0] lo_q;
    bwd_word_t        word_q;

    if (RD_LAT <= 1) begin : g_lat1
        logic v_q;
        logic h_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                h_q <= 1'b0;
            end else begin
                v_q <= s_read;
                h_q <= s_upper;
            end
        end
        assign arr_v  = v_q;
        assign arr_hi = h_q;
    end else begin : g_latn
        logic [RD_LAT-1:0] v_q;
        logic [RD_LAT-1:0] h_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= '0;
                h_q <= '0;
            end else begin
                v_q <= {v_q[RD_LAT-2:0], s_read};
                h_q <= {h_q[RD_LAT-2:0], s_upper};
            end
        end
        assign arr_v  = v_q[RD_LAT-1];
        assign arr_hi = h_q[RD_LAT-1];
    end

    assign hi_arrive = arr_v && arr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q     <= '0;
            word_q   <= '0;
            m_rvalid <= 1'b0;
        end else begin
            m_rvalid <= 1'b0;
            if (arr_v && !arr_hi) begin
                lo_q <= s_rdata;
            end
            if (hi_arrive) begin
                word_q.hi <= s_rdata;
                word_q.lo <= lo_q;
                m_rvalid  <= 1'b1;
            end
        end
    end

    assign m_rdata = word_q;

endmodule

// File: rtl/bus_width_downsizer.sv
// 32-bit master to 16-bit fixed-latency slave width adapter.
module bus_width_downsizer
    import bwd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int RD_LAT  = 1,
    parameter bit POST_WR = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    m_addr,
    input  logic                 m_read,
    input  logic                 m_write,
    input  logic [31:0]          m_wdata,
    input  logic [3:0]           m_be,
    output logic                 m_waitreq,
    output logic [31:0]          m_rdata,
    output logic                 m_rvalid,
    output logic [ADDR_W-2:0]    s_addr,
    output logic                 s_read,
    output logic                 s_write,
    output logic [15:0]          s_wdata,
    output logic [1:0]           s_be,
    input  logic [15:0]          s_rdata
);

    bwd_state_e          state;
    logic                job_rd;
    logic [MST_W-1:0]    job_wdata;
    logic [MST_BE-1:0]   job_be;
    logic [ADDR_W-3:0]   job_waddr;
    logic                hi_arrive;

    bwd_ctrl #(
        .ADDR_W  (ADDR_W),
        .POST_WR (POST_WR)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .m_addr    (m_addr),
        .m_read    (m_read),
        .m_write   (m_write),
        .m_wdata   (m_wdata),
        .m_be      (m_be),
        .hi_arrive (hi_arrive),
        .m_waitreq (m_waitreq),
        .state     (state),
        .job_rd    (job_rd),
        .job_wdata (job_wdata),
        .job_be    (job_be),
        .job_waddr (job_waddr)
    );

    bwd_slv_mux #(
        .ADDR_W (ADDR_W)
    ) u_slv (
        .state     (state),
        .job_rd    (job_rd),
        .job_wdata (job_wdata),
        .job_be    (job_be),
        .job_waddr (job_waddr),
        .s_addr    (s_addr),
        .s_read    (s_read),
        .s_write   (s_write),
        .s_wdata   (s_wdata),
        .s_be      (s_be)
    );

    bwd_rd_gather #(
        .RD_LAT (RD_LAT)
    ) u_gather (
        .clk       (clk),
        .rst       (rst),
        .s_read    (s_read),
        .s_upper   (s_addr[0]),
        .s_rdata   (s_rdata),
        .hi_arrive (hi_arrive),
        .m_rdata   (m_rdata),
        .m_rvalid  (m_rvalid)
    );

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              m_read,
    input logic              m_write,
    input logic              m_waitreq,
    input logic              m_rvalid,
    input logic [ADDR_W-2:0] s_addr,
    input logic              s_read,
    input logic              s_write,
    input logic [1:0]        s_be
);

    // R1: a lower-half read is followed by the upper half of the same word
    p_lo_then_hi_r1: assert property (@(posedge clk) disable iff (rst)
        (s_read && !s_addr[0]) |=>
            (s_read && s_addr[0] && (s_addr[ADDR_W-2:1] == $past(s_addr[ADDR_W-2:1]))));

    // R1: an upper-half read always has a lower-half read just before it
    p_hi_after_lo_r1: assert property (@(posedge clk) disable iff (rst)
        (s_read && s_addr[0]) |-> ($past(s_read) && !$past(s_addr[0])));

    // R1: slave reads use both byte lanes
    p_read_lanes_r1: assert property (@(posedge clk) disable iff (rst)
        s_read |-> (s_be == 2'b11));

    // R2: read-valid is a single-cycle pulse
    p_rvalid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        m_rvalid |=> !m_rvalid);

    // R4: no write half goes out with empty byte enables
    p_no_empty_half_r4: assert property (@(posedge clk) disable iff (rst)
        s_write |-> (s_be != 2'b00));

    // R5: slave strobes never overlap
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(s_read && s_write));

    // R7: the cycle a write completes carries no slave strobe
    p_wr_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (m_write && !m_read && !m_waitreq) |-> (!s_read && !s_write));

    // R10: the cycle after reset is quiet on both sides
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!s_read && !s_write && !m_rvalid));

    // R10: no stall without a command
    p_wait_needs_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        m_waitreq |-> (m_read || m_write));

    // R11: read-valid only at the completion of a read
    p_rvalid_at_done_r11: assert property (@(posedge clk) disable iff (rst)
        m_rvalid |-> (m_read && !m_waitreq));

endmodule

bind bus_width_downsizer bwd_checker #(
    .ADDR_W (ADDR_W)
) u_bwd_chk (
    .clk       (clk),
    .rst       (rst),
    .m_read    (m_read),
    .m_write   (m_write),
    .m_waitreq (m_waitreq),
    .m_rvalid  (m_rvalid),
    .s_addr    (s_addr),
    .s_read    (s_read),
    .s_write   (s_write),
    .s_be      (s_be)
);

// File: tb/tb_bus_width_downsizer.sv
module tb_bus_width_downsizer;

    localparam int AW = 8;
    localparam int NI = 2;          // instance 0: posted, latency 2; instance 1: unposted, latency 1
    localparam int MD = 1 << (AW - 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;           // 125 MHz

    logic rst;

    logic [AW-1:0] m_addr    [NI];
    logic          m_read    [NI];
    logic          m_write   [NI];
    logic [31:0]   m_wdata   [NI];
    logic [3:0]    m_be      [NI];
    logic          m_waitreq [NI];
    logic [31:0]   m_rdata   [NI];
    logic          m_rvalid  [NI];
    logic [AW-2:0] s_addr    [NI];
    logic          s_read    [NI];
    logic          s_write   [NI];
    logic [15:0]   s_wdata   [NI];
    logic [1:0]    s_be      [NI];
    logic [15:0]   s_rdata   [NI];

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    bus_width_downsizer #(.ADDR_W(AW), .RD_LAT(2), .POST_WR(1'b1)) dut (
        .clk(clk), .rst(rst), .m_addr(m_addr[0]), .m_read(m_read[0]), .m_write(m_write[0]),
        .m_wdata(m_wdata[0]), .m_be(m_be[0]), .m_waitreq(m_waitreq[0]), .m_rdata(m_rdata[0]),
        .m_rvalid(m_rvalid[0]), .s_addr(s_addr[0]), .s_read(s_read[0]), .s_write(s_write[0]),
        .s_wdata(s_wdata[0]), .s_be(s_be[0]), .s_rdata(s_rdata[0]));

    bus_width_downsizer #(.ADDR_W(AW), .RD_LAT(1), .POST_WR(1'b0)) dut_np (
        .clk(clk), .rst(rst), .m_addr(m_addr[1]), .m_read(m_read[1]), .m_write(m_write[1]),
        .m_wdata(m_wdata[1]), .m_be(m_be[1]), .m_waitreq(m_waitreq[1]), .m_rdata(m_rdata[1]),
        .m_rvalid(m_rvalid[1]), .s_addr(s_addr[1]), .s_read(s_read[1]), .s_write(s_write[1]),
        .s_wdata(s_wdata[1]), .s_be(s_be[1]), .s_rdata(s_rdata[1]));

    // Fixed-latency RAM models: poison outside the exact data slot
    logic [15:0]   mem    [NI][MD];
    logic [AW-2:0] ev_addr[NI][8];
    logic          ev_wr  [NI][8];
    int            ev_n   [NI];
    int            rv_cnt [NI];

    for (genvar g = 0; g < NI; g++) begin : g_ram
        localparam int L = (g == 0) ? 2 : 1;
        logic        v1 = 1'b0, v2 = 1'b0;
        logic [15:0] d1 = '0,   d2 = '0;
        always @(posedge clk) begin
            v1 <= s_read[g];
            d1 <= mem[g][s_addr[g]];
            v2 <= v1;
            d2 <= d1;
            if (s_write[g]) begin
                if (s_be[g][0]) mem[g][s_addr[g]][7:0]  <= s_wdata[g][7:0];
                if (s_be[g][1]) mem[g][s_addr[g]][15:8] <= s_wdata[g][15:8];
            end
            if (s_read[g] || s_write[g]) begin
                ev_addr[g][ev_n[g] % 8] <= s_addr[g];
                ev_wr[g][ev_n[g] % 8]   <= s_write[g];
                ev_n[g]                 <= ev_n[g] + 1;
            end
        end
        assign s_rdata[g] = (L == 1) ? (v1 ? d1 : 16'hDEAD) : (v2 ? d2 : 16'hDEAD);
        always @(negedge clk) if (m_rvalid[g] === 1'b1) rv_cnt[g] <= rv_cnt[g] + 1;
    end

    function automatic int lat_of(input int i);
        return (i == 0) ? 2 : 1;
    endfunction

    function automatic logic [15:0] merge16(input logic [15:0] old, input logic [15:0] nw,
                                            input logic [1:0] b);
        logic [15:0] r;
        r = old;
        if (b[0]) r[7:0]  = nw[7:0];
        if (b[1]) r[15:8] = nw[15:8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    task automatic chk_ev(input int i, input int idx, input logic [AW-2:0] ea,
                          input bit ew, input string req);
        logic [31:0] act, exp;
        act = {15'd0, ev_wr[i][idx % 8], 9'd0, ev_addr[i][idx % 8]};
        exp = {15'd0, ew, 9'd0, ea};
        chk_eq(req, "slave access order/address", act, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    // One master access; returns stall count and the completion-cycle outputs
    task automatic access(input int i, input bit rd, input logic [AW-1:0] a,
                          input logic [31:0] wd, input logic [3:0] be,
                          output int waits, output logic [31:0] rdat, output logic rv);
        @(negedge clk);
        m_addr[i]  = a;
        m_read[i]  = rd;
        m_write[i] = !rd;
        m_wdata[i] = wd;
        m_be[i]    = rd ? 4'hF : be;
        waits = 0;
        #1;
        while (m_waitreq[i] && waits < 50) begin
            waits++;
            @(negedge clk);
            #1;
        end
        rdat = m_rdata[i];
        rv   = m_rvalid[i];
        @(posedge clk);
        #1;
        m_read[i]  = 1'b0;
        m_write[i] = 1'b0;
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < NI; i++) begin
            chk_eq("R10", "s_read in reset",    32'(s_read[i]),    32'd0);
            chk_eq("R10", "s_write in reset",   32'(s_write[i]),   32'd0);
            chk_eq("R10", "m_rvalid in reset",  32'(m_rvalid[i]),  32'd0);
            chk_eq("R10", "m_waitreq idle",     32'(m_waitreq[i]), 32'd0);
        end
    endtask

    // R1 R2 R3 R11: full read, halves merged, exact latency slot
    task automatic t_read(input int i, input logic [AW-1:0] a);
        int base, rvb, waits;
        logic [31:0] rdat, exp;
        logic rv;
        logic [AW-2:0] lo_a, hi_a;
        lo_a = {a[AW-1:2], 1'b0};
        hi_a = {a[AW-1:2], 1'b1};
        exp  = {mem[i][hi_a], mem[i][lo_a]};
        base = ev_n[i];
        rvb  = rv_cnt[i];
        access(i, 1'b1, a, 32'd0, 4'hF, waits, rdat, rv);
        chk_eq("R2",  "read word",              rdat, exp);
        chk_eq("R11", "rvalid at completion",   32'(rv), 32'd1);
        chk_eq("R3",  "read stall cycles",      32'(waits), 32'(3 + lat_of(i)));
        chk_eq("R2",  "rvalid pulses per read", 32'(rv_cnt[i] - rvb), 32'd1);
        chk_eq("R1",  "slave reads per read",   32'(ev_n[i] - base), 32'd2);
        chk_ev(i, base,     lo_a, 1'b0, "R1");
        chk_ev(i, base + 1, hi_a, 1'b0, "R1");
    endtask

    // R4 R5 R6 R7 R8 R11: write with a given byte-enable pattern
    task automatic t_write(input int i, input logic [AW-1:0] a, input logic [31:0] wd,
                           input logic [3:0] be);
        int base, rvb, waits, n, k;
        logic [31:0] rdat;
        logic rv;
        logic [AW-2:0] lo_a, hi_a;
        logic [15:0] exp_lo, exp_hi;
        lo_a   = {a[AW-1:2], 1'b0};
        hi_a   = {a[AW-1:2], 1'b1};
        exp_lo = merge16(mem[i][lo_a], wd[15:0],  be[1:0]);
        exp_hi = merge16(mem[i][hi_a], wd[31:16], be[3:2]);
        n      = int'(|be[1:0]) + int'(|be[3:2]);
        base   = ev_n[i];
        rvb    = rv_cnt[i];
        access(i, 1'b0, a, wd, be, waits, rdat, rv);
        if (i == 0) chk_eq("R8", "posted write stall", 32'(waits), 32'd0);
        else        chk_eq("R7", "unposted write stall", 32'(waits), 32'(1 + n));
        repeat (3) @(posedge clk);
        #1;
        chk_eq("R4",  "halves issued",      32'(ev_n[i] - base), 32'(n));
        chk_eq("R5",  "lower word content", 32'(mem[i][lo_a]), 32'(exp_lo));
        chk_eq("R5",  "upper word content", 32'(mem[i][hi_a]), 32'(exp_hi));
        chk_eq("R11", "no rvalid on write", 32'(rv_cnt[i] - rvb), 32'd0);
        k = base;
        if (|be[1:0]) begin
            chk_ev(i, k, lo_a, 1'b1, "R6");
            k++;
        end
        if (|be[3:2]) chk_ev(i, k, hi_a, 1'b1, "R6");
    endtask

    // R9: read directly behind a posted write to the same word
    task automatic t_post_hold(input logic [AW-1:0] a, input logic [31:0] wd);
        int base, waits;
        logic [31:0] rdat;
        logic rv;
        logic [AW-2:0] lo_a, hi_a;
        lo_a = {a[AW-1:2], 1'b0};
        hi_a = {a[AW-1:2], 1'b1};
        base = ev_n[0];
        access(0, 1'b0, a, wd, 4'hF, waits, rdat, rv);
        chk_eq("R8", "posted write stall", 32'(waits), 32'd0);
        access(0, 1'b1, a, 32'd0, 4'hF, waits, rdat, rv);
        chk_eq("R9", "read held behind drain", 32'(waits), 32'(2 + 3 + lat_of(0)));
        chk_eq("R9", "read sees posted data",  rdat, wd);
        chk_ev(0, base,     lo_a, 1'b1, "R9");
        chk_ev(0, base + 1, hi_a, 1'b1, "R9");
        chk_ev(0, base + 2, lo_a, 1'b0, "R9");
        chk_ev(0, base + 3, hi_a, 1'b0, "R9");
    endtask

    // R10: reset while the upper half of a posted write is pending
    task automatic t_reset_drain(input logic [AW-1:0] a, input logic [31:0] wd);
        int base, waits;
        logic [31:0] rdat;
        logic rv;
        logic [AW-2:0] lo_a, hi_a;
        logic [15:0] old_hi;
        lo_a   = {a[AW-1:2], 1'b0};
        hi_a   = {a[AW-1:2], 1'b1};
        old_hi = mem[0][hi_a];
        base   = ev_n[0];
        access(0, 1'b0, a, wd, 4'hF, waits, rdat, rv);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk_eq("R10", "s_write low after reset", 32'(s_write[0]), 32'd0);
        chk_eq("R10", "s_read low after reset",  32'(s_read[0]),  32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_eq("R10", "halves before reset only", 32'(ev_n[0] - base), 32'd1);
        chk_eq("R10", "dropped upper half",       32'(mem[0][hi_a]), 32'(old_hi));
        chk_eq("R10", "lower half landed",        32'(mem[0][lo_a]), 32'(wd[15:0]));
        chk_eq("R10", "idle stall low",           32'(m_waitreq[0]), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        for (int i = 0; i < NI; i++) begin
            m_addr[i] = '0; m_read[i] = 1'b0; m_write[i] = 1'b0;
            m_wdata[i] = '0; m_be[i] = '0;
            ev_n[i] = 0; rv_cnt[i] = 0;
            for (int k = 0; k < MD; k++) mem[i][k] = 16'(16'hA000 + i * 256 + k * 3);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_state();
        rst = 1'b0;

        t_read(0, 8'h10);
        t_read(1, 8'h10);
        t_read(0, 8'h4B);
        t_read(1, 8'h7F);

        t_write(0, 8'h20, 32'h1122_3344, 4'hF);
        t_write(1, 8'h20, 32'h5566_7788, 4'hF);
        t_write(1, 8'h24, 32'hAABB_CCDD, 4'b0100);
        t_write(0, 8'h28, 32'h0F1E_2D3C, 4'b0010);
        t_write(0, 8'h2C, 32'hFFFF_FFFF, 4'b0000);
        t_write(1, 8'h2C, 32'hFFFF_FFFF, 4'b0000);
        t_write(1, 8'h30, 32'h9988_7766, 4'b1001);
        t_read(1, 8'h24);
        t_read(1, 8'h30);

        t_post_hold(8'h34, 32'hCAFE_F00D);
        t_reset_drain(8'h38, 32'h1357_9BDF);
        t_read(0, 8'h38);

        finish_run();
    end

endmodule